// File: doc/BRIEF.md
# Store Queue Commit and Writeback Engine

This block tracks stores from the moment they enter the store queue until the data cache has finished with them. A store starts as pending. A commit bound promotes pending stores to writeback-eligible in program order. A writeback pointer then offers eligible stores to the data cache request port, oldest first, up to a per-cycle port budget. Stores whose data size is zero need no memory access, so they finish as soon as the writeback pointer reaches them.

When the cache refuses an offer, the engine parks that one request and stops offering new stores. It offers the parked request again only when the retry input pulses. Completions come back tagged with the queue index and may arrive in any order. The oldest entry is retired only when it is done, and every contiguous done entry behind it retires in the same cycle. A squash removes young, still-pending stores from the tail. It never removes an entry that has already been committed.

Allocation uses a valid/ready handshake: a store is taken on a clock edge where both `alloc_valid` and `alloc_ready` are high. The request port behaves differently from a plain valid/ready stream. An offer that sees `req_ready` low is not held on the request lines. It moves into the parked slot, and `req_valid` stays low until a retry pulse puts it back on lane 0.

Top module: `sqwb_engine`

## Requirements
- R1: After reset the queue is empty: `sq_count` is 0, `alloc_ready` is 1, `wb_blocked` is 0 and no request lane is valid.
- R2: A store is accepted when `alloc_valid` and `alloc_ready` are both high, and `sq_count` rises by one at that edge. `alloc_ready` is low while `sq_count` equals DEPTH.
- R3: A commit pulse walks from the oldest entry toward the youngest. It skips entries that are already committed and stops at the first pending entry whose sequence number is greater than `commit_seq`; every pending entry before that point becomes eligible. A pending store is never offered to the cache.
- R4: Eligible stores are offered oldest first. An offer appears in the cycle after the edge that made the store eligible and the pointer reached it. Each offer carries the store's address, data and size, and a tag equal to its queue index. The first store after reset has index 0, and indices step by one modulo DEPTH. At most PORTS lanes are valid per cycle, filled from lane 0 upward.
- R5: An eligible store of size 0 produces no request. The writeback pointer moves past it in the same cycle, and it counts as done.
- R6: An offer on a lane with `req_ready` low sets `wb_blocked` at the next edge. While blocked, no new store is offered.
- R7: While blocked, a `retry` pulse re-offers the parked request on lane 0 with the same tag. If `req_ready` is high in that cycle, `wb_blocked` clears at the next edge; otherwise it stays set.
- R8: A completion whose tag names an accepted, outstanding request marks that entry done. At the following edge the oldest entry and all contiguous done entries after it are retired, so completions that arrive out of order leave `sq_count` unchanged until the oldest one finishes.
- R9: A squash pulse removes entries from the youngest backward while they are pending and their sequence number is greater than `squash_seq`. It stops at the first committed entry, and `sq_count` drops at the next edge.
- R10: A completion whose tag is not an accepted, outstanding request (including the parked one) has no effect.
- R11: `alloc_ready` is low during a squash pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | New store offered |
| alloc_ready | output | 1 | Queue can take a store this cycle |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data |
| alloc_size | input | SIZE_W | Store size in bytes, 0 means no access |
| commit_valid | input | 1 | Commit bound pulse |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash pulse |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| req_valid | output | PORTS | Per-lane cache write offer |
| req_ready | input | PORTS | Per-lane cache acceptance |
| req_tag | output | PORTS*IDX_W | Per-lane queue index |
| req_addr | output | PORTS*ADDR_W | Per-lane address |
| req_data | output | PORTS*DATA_W | Per-lane data |
| req_size | output | PORTS*SIZE_W | Per-lane size |
| retry | input | 1 | Cache asks for the parked request again |
| cpl_valid | input | 1 | Write completion |
| cpl_tag | input | IDX_W | Queue index of the completed write |
| wb_blocked | output | 1 | A refused request is parked |
| sq_count | output | IDX_W+1 | Entries held in the queue |

## Verification
Request lanes are combinational from the registered state and the ready and retry inputs. An offer therefore appears in the cycle after the commit pulse's edge and is compared in that same cycle. `wb_blocked` and `sq_count` are registered. They change one edge after a refusal, retry, completion, squash or allocation, and each check of them is placed in the cycle that follows that edge. Inputs change just after the rising edge and every output is sampled on the falling edge. A cycle-level bench model, stepped once per edge, predicts each output in the cycle it is due.

// File: rtl/sqwb_pkg.sv
package sqwb_pkg;
  // Lifecycle of one store queue slot.
  typedef enum logic [2:0] {
    SQ_FREE = 3'd0,
    SQ_PEND = 3'd1,
    SQ_ELIG = 3'd2,
    SQ_SENT = 3'd3,
    SQ_DONE = 3'd4
  } sq_state_e;
endpackage

// File: rtl/sqwb_mark.sv
// Commit marking walk: oldest to youngest, stops at first young pending entry.
module sqwb_mark
  import sqwb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic [PTR_W-1:0]  head,
  input  logic [PTR_W-1:0]  count,
  input  sq_state_e         st   [DEPTH],
  input  logic [SEQ_W-1:0]  seq  [DEPTH],
  output logic [DEPTH-1:0]  mark,
  output logic [PTR_W-1:0]  mark_cnt
);
  logic             stop;
  logic [IDX_W-1:0] idx;

  always_comb begin
    mark     = '0;
    mark_cnt = '0;
    stop     = !commit_valid;
    idx      = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head[IDX_W-1:0] + IDX_W'(i);
      if (!stop && PTR_W'(i) < count && st[idx] == SQ_PEND) begin
        if (seq[idx] > commit_seq) begin
          stop = 1'b1;
        end else begin
          mark[idx] = 1'b1;
          mark_cnt  = mark_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sqwb_issue.sv
// Writeback walk: offers eligible stores within the port budget, handles retry.
module sqwb_issue
  import sqwb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SIZE_W = 4,
  parameter int PORTS  = 1,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1,
  localparam int USED_W = $clog2(PORTS + 1)
) (
  input  logic [PTR_W-1:0]           wb_ptr,
  input  logic [PTR_W-1:0]           tail_ptr,
  input  logic [PTR_W-1:0]           to_wb,
  input  logic                       blocked,
  input  logic                       retry,
  input  logic [IDX_W-1:0]           slot_tag,
  input  logic [PORTS-1:0]           req_ready,
  input  sq_state_e                  st   [DEPTH],
  input  logic [SIZE_W-1:0]          size [DEPTH],
  output logic [PORTS-1:0]           lane_valid,
  output logic [PORTS-1:0][IDX_W-1:0] lane_tag,
  output logic [DEPTH-1:0]           sent,
  output logic [DEPTH-1:0]           zs,
  output logic [PTR_W-1:0]           zs_cnt,
  output logic [PTR_W-1:0]           wb_step,
  output logic                       blk_set,
  output logic                       blk_clr,
  output logic [IDX_W-1:0]           new_slot
);
  logic              stop;
  logic [USED_W-1:0] used;
  logic [PTR_W-1:0]  rem;
  logic [PTR_W-1:0]  ptr;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    lane_valid = '0;
    lane_tag   = '0;
    sent       = '0;
    zs         = '0;
    zs_cnt     = '0;
    wb_step    = '0;
    blk_set    = 1'b0;
    blk_clr    = 1'b0;
    new_slot   = '0;
    used       = '0;
    rem        = to_wb;
    stop       = blocked;
    ptr        = '0;
    idx        = '0;
    if (blocked && retry) begin
      lane_valid[0] = 1'b1;
      lane_tag[0]   = slot_tag;
      blk_clr       = req_ready[0];
    end
    for (int i = 0; i < DEPTH; i++) begin
      ptr = wb_ptr + PTR_W'(i);
      idx = ptr[IDX_W-1:0];
      if (!stop) begin
        if (ptr == tail_ptr || rem == '0 || st[idx] != SQ_ELIG ||
            used == USED_W'(PORTS)) begin
          stop = 1'b1;
        end else if (size[idx] == '0) begin
          zs[idx] = 1'b1;
          zs_cnt  = zs_cnt + 1'b1;
          rem     = rem - 1'b1;
          wb_step = wb_step + 1'b1;
        end else begin
          for (int l = 0; l < PORTS; l++) begin
            if (USED_W'(l) == used) begin
              lane_valid[l] = 1'b1;
              lane_tag[l]   = idx;
              if (!req_ready[l]) begin
                blk_set  = 1'b1;
                new_slot = idx;
                stop     = 1'b1;
              end
            end
          end
          sent[idx] = 1'b1;
          wb_step   = wb_step + 1'b1;
          used      = used + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sqwb_retire.sv
// Head retirement over contiguous done entries and tail squash walk.
module sqwb_retire
  import sqwb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic [PTR_W-1:0]  head,
  input  logic [PTR_W-1:0]  tail,
  input  logic [PTR_W-1:0]  count,
  input  logic [DEPTH-1:0]  done_view,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  sq_state_e         st  [DEPTH],
  input  logic [SEQ_W-1:0]  seq [DEPTH],
  output logic [DEPTH-1:0]  free,
  output logic [PTR_W-1:0]  hd_step,
  output logic [DEPTH-1:0]  kill,
  output logic [PTR_W-1:0]  sq_step
);
  logic             hstop, sstop;
  logic [IDX_W-1:0] hidx, sidx;

  always_comb begin
    free    = '0;
    hd_step = '0;
    kill    = '0;
    sq_step = '0;
    hstop   = 1'b0;
    sstop   = !squash_valid;
    hidx    = '0;
    sidx    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hidx = head[IDX_W-1:0] + IDX_W'(i);
      if (!hstop && PTR_W'(i) < count && done_view[hidx]) begin
        free[hidx] = 1'b1;
        hd_step    = hd_step + 1'b1;
      end else begin
        hstop = 1'b1;
      end
      sidx = tail[IDX_W-1:0] - IDX_W'(i + 1);
      if (!sstop && PTR_W'(i) < count && st[sidx] == SQ_PEND &&
          seq[sidx] > squash_seq) begin
        kill[sidx] = 1'b1;
        sq_step    = sq_step + 1'b1;
      end else begin
        sstop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sqwb_engine.sv
// Store queue commit / writeback engine top. DEPTH must be a power of two.
module sqwb_engine
  import sqwb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 4,
  parameter int PORTS  = 1,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  output logic                      alloc_ready,
  input  logic [SEQ_W-1:0]          alloc_seq,
  input  logic [ADDR_W-1:0]         alloc_addr,
  input  logic [DATA_W-1:0]         alloc_data,
  input  logic [SIZE_W-1:0]         alloc_size,
  input  logic                      commit_valid,
  input  logic [SEQ_W-1:0]          commit_seq,
  input  logic                      squash_valid,
  input  logic [SEQ_W-1:0]          squash_seq,
  output logic [PORTS-1:0]          req_valid,
  input  logic [PORTS-1:0]          req_ready,
  output logic [PORTS*IDX_W-1:0]    req_tag,
  output logic [PORTS*ADDR_W-1:0]   req_addr,
  output logic [PORTS*DATA_W-1:0]   req_data,
  output logic [PORTS*SIZE_W-1:0]   req_size,
  input  logic                      retry,
  input  logic                      cpl_valid,
  input  logic [IDX_W-1:0]          cpl_tag,
  output logic                      wb_blocked,
  output logic [PTR_W-1:0]          sq_count
);
  sq_state_e         ent_st   [DEPTH];
  logic [SEQ_W-1:0]  ent_seq  [DEPTH];
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [SIZE_W-1:0] ent_size [DEPTH];

  logic [PTR_W-1:0] head_q, tail_q, wb_q, to_wb_q, count;
  logic             blocked_q;
  logic [IDX_W-1:0] slot_q;

  logic [DEPTH-1:0] mark, sent, zs, free, kill, done_view;
  logic [PTR_W-1:0] mark_cnt, zs_cnt, wb_step, hd_step, sq_step;
  logic             blk_set, blk_clr, cpl_hit, alloc_fire;
  logic [IDX_W-1:0] new_slot;
  logic [PORTS-1:0][IDX_W-1:0] lane_tag;

  assign count       = tail_q - head_q;
  assign alloc_ready = (count != PTR_W'(DEPTH)) && !squash_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign cpl_hit     = cpl_valid && ent_st[cpl_tag] == SQ_SENT &&
                       !(blocked_q && slot_q == cpl_tag);
  assign wb_blocked  = blocked_q;
  assign sq_count    = count;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      done_view[j] = ent_st[j] == SQ_DONE || zs[j] ||
                     (cpl_hit && cpl_tag == IDX_W'(j));
    end
  end

  sqwb_mark #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_mark (
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .head(head_q), .count(count), .st(ent_st), .seq(ent_seq),
    .mark(mark), .mark_cnt(mark_cnt)
  );

  sqwb_issue #(.DEPTH(DEPTH), .SIZE_W(SIZE_W), .PORTS(PORTS)) u_issue (
    .wb_ptr(wb_q), .tail_ptr(tail_q), .to_wb(to_wb_q), .blocked(blocked_q),
    .retry(retry), .slot_tag(slot_q), .req_ready(req_ready),
    .st(ent_st), .size(ent_size), .lane_valid(req_valid), .lane_tag(lane_tag),
    .sent(sent), .zs(zs), .zs_cnt(zs_cnt), .wb_step(wb_step),
    .blk_set(blk_set), .blk_clr(blk_clr), .new_slot(new_slot)
  );

  sqwb_retire #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_retire (
    .head(head_q), .tail(tail_q), .count(count), .done_view(done_view),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .st(ent_st), .seq(ent_seq), .free(free), .hd_step(hd_step),
    .kill(kill), .sq_step(sq_step)
  );

  // Request lanes read their payload from the tagged entry.
  for (genvar l = 0; l < PORTS; l++) begin : g_lane
    assign req_tag [l*IDX_W  +: IDX_W ] = lane_tag[l];
    assign req_addr[l*ADDR_W +: ADDR_W] = ent_addr[lane_tag[l]];
    assign req_data[l*DATA_W +: DATA_W] = ent_data[lane_tag[l]];
    assign req_size[l*SIZE_W +: SIZE_W] = ent_size[lane_tag[l]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) ent_st[j] <= SQ_FREE;
    end else begin
      for (int j = 0; j < DEPTH; j++) begin
        if (free[j] || kill[j])                               ent_st[j] <= SQ_FREE;
        else if (zs[j] || (cpl_hit && cpl_tag == IDX_W'(j)))  ent_st[j] <= SQ_DONE;
        else if (sent[j])                                     ent_st[j] <= SQ_SENT;
        else if (mark[j])                                     ent_st[j] <= SQ_ELIG;
        else if (alloc_fire && tail_q[IDX_W-1:0] == IDX_W'(j)) ent_st[j] <= SQ_PEND;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < DEPTH; j++) begin
      if (alloc_fire && tail_q[IDX_W-1:0] == IDX_W'(j)) begin
        ent_seq[j]  <= alloc_seq;
        ent_addr[j] <= alloc_addr;
        ent_data[j] <= alloc_data;
        ent_size[j] <= alloc_size;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q    <= '0;
      tail_q    <= '0;
      wb_q      <= '0;
      to_wb_q   <= '0;
      blocked_q <= 1'b0;
      slot_q    <= '0;
    end else begin
      head_q  <= head_q + hd_step;
      tail_q  <= tail_q - sq_step + PTR_W'(alloc_fire);
      wb_q    <= wb_q + wb_step;
      to_wb_q <= to_wb_q + mark_cnt - zs_cnt - PTR_W'(cpl_hit);
      if (blk_set) begin
        blocked_q <= 1'b1;
        slot_q    <= new_slot;
      end else if (blk_clr) begin
        blocked_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sqwb_engine_chk.sv
module sqwb_engine_chk #(
  parameter int DEPTH = 8,
  parameter int PORTS = 1,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             squash_valid,
  input logic [PORTS-1:0] req_valid,
  input logic [PORTS-1:0] req_ready,
  input logic             retry,
  input logic             wb_blocked,
  input logic [PTR_W-1:0] sq_count
);
  // R2
  full_stalls_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_count == PTR_W'(DEPTH) |-> !alloc_ready);
  // R2
  count_grows_only_by_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_valid && alloc_ready) |=> sq_count <= $past(sq_count));
  // R11
  no_alloc_in_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> !alloc_ready);
  // R4
  lanes_fill_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid[0] |-> req_valid == '0);
  // R6
  refusal_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_blocked && req_valid[0] && !req_ready[0] |=> wb_blocked);
  // R6
  blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_blocked && !retry |-> req_valid == '0);
  // R7
  retry_accept_unblocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_blocked && retry && req_ready[0] |=> !wb_blocked);
  // R7
  stays_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_blocked && !(retry && req_ready[0]) |=> wb_blocked);
endmodule

bind sqwb_engine sqwb_engine_chk #(.DEPTH(DEPTH), .PORTS(PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .squash_valid(squash_valid), .req_valid(req_valid), .req_ready(req_ready),
  .retry(retry), .wb_blocked(wb_blocked), .sq_count(sq_count)
);

// File: tb/sqwb_engine_bench.sv
`timescale 1ns/1ps
module sqwb_engine_bench;
  localparam int DEPTH = 8, SEQ_W = 16, ADDR_W = 32, DATA_W = 32, SIZE_W = 4;
  localparam int PORTS = 1, IDX_W = 3, PTR_W = 4;
  localparam int FR = 0, PE = 1, EL = 2, SE = 3, DN = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid, alloc_ready, commit_valid, squash_valid, retry, cpl_valid, wb_blocked;
  logic [SEQ_W-1:0]  alloc_seq, commit_seq, squash_seq;
  logic [ADDR_W-1:0] alloc_addr, req_addr;
  logic [DATA_W-1:0] alloc_data, req_data;
  logic [SIZE_W-1:0] alloc_size, req_size;
  logic [PORTS-1:0]  req_valid, req_ready;
  logic [IDX_W-1:0]  req_tag, cpl_tag;
  logic [PTR_W-1:0]  sq_count;

  always #2 clk = ~clk;

  sqwb_engine u_sqwb_engine (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_seq(alloc_seq), .alloc_addr(alloc_addr), .alloc_data(alloc_data),
    .alloc_size(alloc_size), .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .req_valid(req_valid),
    .req_ready(req_ready), .req_tag(req_tag), .req_addr(req_addr), .req_data(req_data),
    .req_size(req_size), .retry(retry), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .wb_blocked(wb_blocked), .sq_count(sq_count)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_st [DEPTH];
  int m_seq[DEPTH], m_size[DEPTH];
  logic [ADDR_W-1:0] m_addr[DEPTH];
  logic [DATA_W-1:0] m_data[DEPTH];
  int m_head = 0, m_tail = 0, m_wb = 0, m_slot = 0;
  bit m_blk = 0;
  int next_seq = 1, last_commit = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_valid = 0; alloc_seq = '0; alloc_addr = '0; alloc_data = '0; alloc_size = '0;
    commit_valid = 0; commit_seq = '0; squash_valid = 0; squash_seq = '0;
    req_ready = 1'b1; retry = 0; cpl_valid = 0; cpl_tag = '0;
  endtask

  task automatic set_alloc(int s, int sz);
    alloc_valid = 1; alloc_seq = SEQ_W'(s); alloc_size = SIZE_W'(sz);
    alloc_addr = 32'h1000 + 32'(s) * 4; alloc_data = 32'(s) * 32'h01010101;
  endtask

  // Expected offer from the model (R4, R5, R6, R7).
  task automatic compare();
    int ev = 0, et = 0, p;
    if (m_blk) begin
      if (retry) begin ev = 1; et = m_slot; end
    end else begin
      p = m_wb;
      while (p < m_tail && m_st[p % DEPTH] == EL) begin
        if (m_size[p % DEPTH] == 0) p++;
        else begin ev = 1; et = p % DEPTH; break; end
      end
    end
    chk("R4 req_valid", req_valid, ev);
    if (ev == 1) begin
      chk("R4 req_tag", req_tag, et);
      chk("R4 req_addr", req_addr, m_addr[et]);
      chk("R4 req_data", req_data, m_data[et]);
      chk("R4 req_size", req_size, m_size[et]);
    end
    chk("R6 wb_blocked", wb_blocked, m_blk);
    chk("R8 sq_count", sq_count, m_tail - m_head);
    chk("R2 alloc_ready", alloc_ready, (m_tail - m_head < DEPTH) && !squash_valid);
  endtask

  task automatic model_step();
    int cnt0 = m_tail - m_head, p, used = 0;
    if (cpl_valid && m_st[cpl_tag] == SE && !(m_blk && m_slot == int'(cpl_tag)))
      m_st[cpl_tag] = DN;
    if (m_blk) begin
      if (retry && req_ready[0]) m_blk = 0;
    end else begin
      p = m_wb;
      while (p < m_tail && m_st[p % DEPTH] == EL) begin
        if (m_size[p % DEPTH] == 0) begin m_st[p % DEPTH] = DN; p++; end
        else if (used < PORTS) begin
          m_st[p % DEPTH] = SE; p++; used++;
          if (!req_ready[0]) begin m_blk = 1; m_slot = (p - 1) % DEPTH; break; end
        end else break;
      end
      m_wb = p;
    end
    while (m_head < m_tail && m_st[m_head % DEPTH] == DN) begin
      m_st[m_head % DEPTH] = FR; m_head++;
    end
    if (commit_valid)
      for (int q = m_head; q < m_tail; q++)
        if (m_st[q % DEPTH] == PE) begin
          if (m_seq[q % DEPTH] > int'(commit_seq)) break;
          m_st[q % DEPTH] = EL;
        end
    if (squash_valid)
      while (m_tail > m_head && m_st[(m_tail - 1) % DEPTH] == PE &&
             m_seq[(m_tail - 1) % DEPTH] > int'(squash_seq)) begin
        m_st[(m_tail - 1) % DEPTH] = FR; m_tail--;
      end
    if (alloc_valid && cnt0 < DEPTH && !squash_valid) begin
      m_st[m_tail % DEPTH] = PE; m_seq[m_tail % DEPTH] = int'(alloc_seq);
      m_addr[m_tail % DEPTH] = alloc_addr; m_data[m_tail % DEPTH] = alloc_data;
      m_size[m_tail % DEPTH] = int'(alloc_size); m_tail++;
    end
  endtask

  task automatic half();
    @(negedge clk);
    compare();
  endtask

  task automatic finish_cycle();
    model_step();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic rand_inputs();
    int t;
    req_ready = 1'(($urandom % 4) != 0);
    if (m_blk && ($urandom % 3 == 0)) retry = 1;
    if ($urandom % 25 == 0) begin
      squash_valid = 1;
      squash_seq = SEQ_W'(last_commit + int'($urandom % (next_seq - last_commit)));
    end else begin
      if ($urandom % 2 == 1) begin
        set_alloc(next_seq, ($urandom % 4 == 0) ? 0 : 1 + int'($urandom % 8));
        alloc_addr = $urandom; alloc_data = $urandom;
        if (m_tail - m_head < DEPTH) next_seq++;
      end
      if ($urandom % 3 == 0) begin
        last_commit = last_commit + int'($urandom % (next_seq - last_commit));
        commit_valid = 1; commit_seq = SEQ_W'(last_commit);
      end
    end
    t = int'($urandom % DEPTH);
    if ($urandom % 10 == 0) begin
      cpl_valid = 1; cpl_tag = IDX_W'(t);
    end else if ($urandom % 5 < 2) begin
      for (int k = 0; k < DEPTH; k++) begin
        int ix = (t + k) % DEPTH;
        if (m_st[ix] == SE && !(m_blk && m_slot == ix)) begin
          cpl_valid = 1; cpl_tag = IDX_W'(ix); break;
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int j = 0; j < DEPTH; j++) begin
      m_st[j] = FR; m_seq[j] = 0; m_size[j] = 0; m_addr[j] = '0; m_data[j] = '0;
    end
    idle_inputs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    half();
    chk("R1 sq_count", sq_count, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 wb_blocked", wb_blocked, 0);
    chk("R1 alloc_ready", alloc_ready, 1);
    finish_cycle();
    // four stores, the second of size 0
    for (int s = 1; s <= 4; s++) begin
      set_alloc(s, (s == 2) ? 0 : 4);
      half(); finish_cycle();
    end
    next_seq = 5;
    half();
    chk("R2 count after four allocs", sq_count, 4);
    chk("R3 nothing offered before commit", req_valid, 0);
    finish_cycle();
    commit_valid = 1; commit_seq = 2; last_commit = 2; req_ready = 0;
    half(); finish_cycle();
    req_ready = 0;
    half();
    chk("R4 first offer valid", req_valid, 1);
    chk("R4 first offer tag", req_tag, 0);
    finish_cycle();
    half();
    chk("R6 blocked after refusal", wb_blocked, 1);
    chk("R6 no offer while blocked", req_valid, 0);
    finish_cycle();
    retry = 1; req_ready = 0;
    half();
    chk("R7 retry re-offers", req_valid, 1);
    chk("R7 retry tag", req_tag, 0);
    finish_cycle();
    half();
    chk("R7 refused retry stays blocked", wb_blocked, 1);
    finish_cycle();
    retry = 1;
    half(); finish_cycle();
    half();
    chk("R7 accepted retry unblocks", wb_blocked, 0);
    chk("R5 zero-size store makes no request, R3 stops at seq 3", req_valid, 0);
    finish_cycle();
    commit_valid = 1; commit_seq = 4; last_commit = 4;
    half(); finish_cycle();
    half(); chk("R4 offer tag 2", req_tag, 2); finish_cycle();
    half(); chk("R4 offer tag 3", req_tag, 3); finish_cycle();
    cpl_valid = 1; cpl_tag = 2;
    half(); finish_cycle();
    cpl_valid = 1; cpl_tag = 3;
    half(); chk("R8 out-of-order completion holds head", sq_count, 4); finish_cycle();
    cpl_valid = 1; cpl_tag = 0;
    half(); chk("R8 still held", sq_count, 4); finish_cycle();
    half(); chk("R8 bulk retire", sq_count, 0); finish_cycle();
    // squash and stray completion
    for (int s = 5; s <= 7; s++) begin
      set_alloc(s, 8);
      half(); finish_cycle();
    end
    next_seq = 8;
    commit_valid = 1; commit_seq = 5; last_commit = 5;
    half(); finish_cycle();
    req_ready = 0;
    half(); chk("R4 offer tag 4", req_tag, 4); finish_cycle();
    cpl_valid = 1; cpl_tag = 4;
    half(); finish_cycle();
    half(); chk("R10 parked completion ignored", sq_count, 3); finish_cycle();
    squash_valid = 1; squash_seq = 5;
    half(); chk("R11 alloc_ready low in squash", alloc_ready, 0); finish_cycle();
    half(); chk("R9 squash stops at committed entry", sq_count, 1); finish_cycle();
    retry = 1;
    half(); finish_cycle();
    cpl_valid = 1; cpl_tag = 4;
    half(); finish_cycle();
    half(); chk("R8 queue drained", sq_count, 0); finish_cycle();
    // constrained random phase against the model
    for (int c = 0; c < 3000; c++) begin
      rand_inputs();
      half();
      finish_cycle();
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule